// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A free-running oversample tick comes in from outside, at either sixteen or eight ticks per bit period; one control input selects which. The line passes through a two-flop synchronizer. A falling edge on the synchronized line starts a tick counter. Half a bit period later the block samples the line again. If the line has gone back high, the event was a glitch: the block drops it and returns to idle.

Once a start bit is confirmed, the block samples the line once per full bit period at each bit center. It does this for five to eight data bits (least significant bit first), then an optional parity bit, then the stop bit. At the stop-bit center it registers the character together with parity, framing and break flags, and raises a one-cycle valid strobe. The mode, word length and parity settings are captured when the start edge is seen and stay fixed for the rest of that character.

Top module: `uart_os_rx`

## Requirements
- R1: During and right after a synchronous reset, `rx_valid`, `rx_data`, `err_parity`, `err_frame` and `err_break` are all 0.
- R2: If the line is high again at the start-bit center, no character is produced and the receiver goes back to waiting for a new falling edge. The start-bit center is 8 ticks after the edge with `os_half`=0, and 4 ticks with `os_half`=1.
- R3: Bit periods are 16 ticks with `os_half`=0 and 8 ticks with `os_half`=1. Every bit after the start bit is sampled one full period after the previous one, so `rx_valid` rises while the stop bit is still on the line.
- R4: `word_len` encodes the number of data bits as 0→5, 1→6, 2→7, 3→8. Data arrives least significant bit first into `rx_data[0]` upward, and the unused upper bits of `rx_data` read 0.
- R5: With `par_en`=1 a parity bit follows the data. `err_parity` is 1 when the count of ones over the data and parity bits is odd with `par_odd`=0 (even parity), or even with `par_odd`=1 (odd parity).
- R6: With `par_en`=0 no parity slot exists (the stop bit follows the last data bit) and `err_parity` is 0.
- R7: `err_frame` is 1 exactly when the stop bit is sampled low.
- R8: `err_break` is 1 exactly when all data bits, the parity bit (if enabled) and the stop bit are sampled low.
- R9: Each accepted character raises `rx_valid` for exactly one clock. The data and flags stay unchanged until the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample tick enable, one clock wide |
| os_half | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| word_len | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Received character, upper unused bits 0 |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| err_parity | output | 1 | Parity mismatch for this character |
| err_frame | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Whole character including stop sampled low |

## Verification
The line edge takes two clocks to reach the edge detector, and the first tick after detection is used to start the counter. As a result, every sample lands one tick after the true bit center. The character, its flags and `rx_valid` appear one clock after the stop-center tick, which is half a bit into the stop bit. The bench drives the line in whole tick counts. It counts every strobe but accepts one only while it is still driving the stop bit, and it checks data and flags after a short idle gap in which they must hold. For a false start, the bench waits a full character time after the glitch and confirms that no strobe appeared.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic       half_os;
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
  } rx_cfg_t;

  function automatic logic [3:0] wlen_bits(input logic [1:0] w);
    return 4'd5 + {2'b00, w};
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_os_timer.sv
module rx_os_timer #(
  parameter int OS_WIDE   = 16,
  parameter int OS_NARROW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic narrow,
  output logic mid_hit,
  output logic end_hit
);
  localparam int CW = $clog2(OS_WIDE);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] mid_idx;

  assign last_idx = narrow ? CW'(OS_NARROW - 1)   : CW'(OS_WIDE - 1);
  assign mid_idx  = narrow ? CW'(OS_NARROW/2 - 1) : CW'(OS_WIDE/2 - 1);

  assign mid_hit = tick && (cnt == mid_idx);
  assign end_hit = tick && (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == last_idx) ? '0 : cnt + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line,
  input  logic                fall,
  input  logic                mid_hit,
  input  logic                end_hit,
  input  rx_cfg_t             cfg_in,
  output logic                timer_clear,
  output logic                cfg_narrow,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_break
);
  localparam int BW = $clog2(DATA_MAX);

  rx_state_e           state;
  rx_cfg_t             cfg_q;
  logic [DATA_MAX-1:0] shreg;
  logic [BW-1:0]       bit_idx;
  logic [BW-1:0]       last_bit;
  logic                par_bit;

  assign last_bit    = BW'(wlen_bits(cfg_q.wlen) - 4'd1);
  assign cfg_narrow  = cfg_q.half_os;
  assign timer_clear = (state == RX_IDLE) || (state == RX_START && mid_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cfg_q      <= '0;
      shreg      <= '0;
      bit_idx    <= '0;
      par_bit    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      err_break  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (fall) begin
            cfg_q   <= cfg_in;
            shreg   <= '0;
            bit_idx <= '0;
            par_bit <= 1'b0;
            state   <= RX_START;
          end
        end
        RX_START: begin
          if (mid_hit) state <= line ? RX_IDLE : RX_DATA;
        end
        RX_DATA: begin
          if (end_hit) begin
            shreg[bit_idx] <= line;
            if (bit_idx == last_bit) begin
              state <= cfg_q.par_en ? RX_PAR : RX_STOP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        RX_PAR: begin
          if (end_hit) begin
            par_bit <= line;
            state   <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (end_hit) begin
            rx_valid   <= 1'b1;
            rx_data    <= shreg;
            err_frame  <= ~line;
            err_break  <= ~line & ~par_bit & (shreg == '0);
            err_parity <= cfg_q.par_en & (^shreg ^ par_bit ^ cfg_q.par_odd);
            state      <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && mid_hit && line) |=> (state == RX_IDLE && !rx_valid));

  // R4
  bit_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA) |-> (bit_idx <= last_bit));

  // R6
  no_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(cfg_q.par_en)) |-> !err_parity);

  // R8
  break_frame_chk: assert property (@(posedge clk) disable iff (rst)
    err_break |-> err_frame);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
#(
  parameter int OS_WIDE     = 16,
  parameter int OS_NARROW   = 8,
  parameter int DATA_MAX    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                os_tick,
  input  logic                os_half,
  input  logic [1:0]          word_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rx_in,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_break
);
  logic    line_s;
  logic    line_fall;
  logic    mid_hit;
  logic    end_hit;
  logic    timer_clear;
  logic    cfg_narrow;
  rx_cfg_t cfg_in;

  assign cfg_in = '{half_os: os_half, wlen: word_len, par_en: par_en, par_odd: par_odd};

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .line (line_s),
    .fall (line_fall)
  );

  rx_os_timer #(.OS_WIDE(OS_WIDE), .OS_NARROW(OS_NARROW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .clear   (timer_clear),
    .narrow  (cfg_narrow),
    .mid_hit (mid_hit),
    .end_hit (end_hit)
  );

  rx_framer #(.DATA_MAX(DATA_MAX)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .line        (line_s),
    .fall        (line_fall),
    .mid_hit     (mid_hit),
    .end_hit     (end_hit),
    .cfg_in      (cfg_in),
    .timer_clear (timer_clear),
    .cfg_narrow  (cfg_narrow),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break)
  );

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       os_half = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_in = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, err_parity, err_frame, err_break;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int tdiv = 0;
  int vtotal = 0;
  int vearly = 0;
  logic in_stop = 1'b0;
  logic [7:0] cap_data;
  logic cap_par, cap_frame, cap_break;
  logic done = 1'b0;

  always #2 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .os_half(os_half),
    .word_len(word_len), .par_en(par_en), .par_odd(par_odd), .rx_in(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_break(err_break)
  );

  always @(negedge clk) begin
    os_tick <= (tdiv == 0);
    tdiv    <= (tdiv == 2) ? 0 : tdiv + 1;
  end

  always @(posedge clk) if (os_tick) tick_cnt <= tick_cnt + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      vtotal    <= vtotal + 1;
      if (!in_stop) vearly <= vearly + 1;
      cap_data  <= rx_data;
      cap_par   <= err_parity;
      cap_frame <= err_frame;
      cap_break <= err_break;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_cnt + n;
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input int len);
    rx_in = v;
    wait_ticks(len);
  endtask

  task automatic send_frame(input logic narrow, input logic [1:0] wl, input logic pe,
                            input logic po, input logic [7:0] data, input logic flip,
                            input logic stop_v);
    int full, nb, base, early0;
    logic [7:0] m;
    logic pbit, e_par, e_brk;
    full = narrow ? 8 : 16;
    nb = 5 + int'(wl);
    m = data & 8'((1 << nb) - 1);
    pbit = pe ? ((^m) ^ po ^ flip) : 1'b0;
    e_par = pe & flip;
    e_brk = ~stop_v & (m == 8'h00) & ~pbit;
    os_half = narrow; word_len = wl; par_en = pe; par_odd = po;
    base = vtotal; early0 = vearly;
    drive_bit(1'b0, full);
    for (int i = 0; i < nb; i++) drive_bit(m[i], full);
    if (pe) drive_bit(pbit, full);
    in_stop = 1'b1;
    drive_bit(stop_v, full);
    in_stop = 1'b0;
    drive_bit(1'b1, 4);
    check(vtotal - base == 1, "R9 one strobe", vtotal - base, 1);
    check(vearly == early0, "R3 strobe inside stop bit", vearly - early0, 0);
    check(cap_data == m, "R4 data", cap_data, m);
    if (pe) check(cap_par == e_par, "R5 parity flag", cap_par, e_par);
    else    check(cap_par == 1'b0, "R6 parity flag off", cap_par, 0);
    check(cap_frame == ~stop_v, "R7 frame flag", cap_frame, ~stop_v);
    check(cap_break == e_brk, "R8 break flag", cap_break, e_brk);
    check(rx_data == m && !rx_valid, "R9 data held", rx_data, m);
  endtask

  task automatic glitch(input logic narrow, input int low_ticks);
    int base;
    os_half = narrow;
    base = vtotal;
    drive_bit(1'b0, low_ticks);
    drive_bit(1'b1, 200);
    check(vtotal == base, "R2 false start dropped", vtotal - base, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!rx_valid && rx_data == 8'h00, "R1 reset outputs", {rx_valid, rx_data}, 0);
    check({err_parity, err_frame, err_break} == 3'b000, "R1 reset flags",
          {err_parity, err_frame, err_break}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!rx_valid && rx_data == 8'h00, "R1 after reset", {rx_valid, rx_data}, 0);
    wait_ticks(4);

    for (int md = 0; md < 2; md++)
      for (int wl = 0; wl < 4; wl++)
        for (int pm = 0; pm < 3; pm++)
          for (int k = 0; k < 3; k++)
            send_frame(md[0], wl[1:0], pm != 0, pm == 2,
                       8'hA5 ^ 8'(k * 8'h3B) ^ 8'(wl * 16 + pm * 4 + md), 1'b0, 1'b1);

    // R5 flipped parity bit, even and odd, both modes
    send_frame(1'b0, 2'd3, 1'b1, 1'b0, 8'h37, 1'b1, 1'b1);
    send_frame(1'b1, 2'd1, 1'b1, 1'b1, 8'h2C, 1'b1, 1'b1);
    // R7 stop low with nonzero data
    send_frame(1'b0, 2'd2, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0);
    send_frame(1'b1, 2'd3, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0);
    // R8 line held low through the whole character
    send_frame(1'b0, 2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    send_frame(1'b1, 2'd0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
    // R8 odd parity of zero data puts a 1 in the parity slot: no break
    send_frame(1'b0, 2'd1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);

    // R2 glitches shorter than half a bit in each mode, then a good frame
    glitch(1'b0, 3);
    send_frame(1'b0, 2'd3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1);
    glitch(1'b1, 1);
    send_frame(1'b1, 2'd3, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule